// File: doc/BRIEF.md
# Real-Time Clock Update Sequencer and Control Register

This block supervises the once-per-second update of a real-time clock and holds the byte-wide control register that configures it. Each one-second tick opens an update window. The block raises a readable busy flag a fixed number of clock cycles before it sends a start pulse to the timekeeping counters. The flag stays high until the counters return a completion strobe. A host polling the flag therefore never reads time registers that are about to change.

The control register holds four interrupt enables (transfer-hold, periodic, alarm, update-ended), a number-format select, an hour-mode select and a seasonal-time enable. Its bit values drive the outputs of the block directly. Setting the transfer-hold bit has three effects:
- it blocks copying of new time into the user-visible registers;
- it masks the busy flag;
- it clears the update-ended enable.

When an update completes with that enable set, the block latches an interrupt request. A host read of the status byte clears it.

Top module: `rtc_upd_ctrl`

## Requirements
- R1: After reset, the control byte reads 0x00, the status byte reads 0x00, and `uip`, `upd_irq`, `upd_go` and every enable output are 0.
- R2: The control byte (host_sel=1) has this layout: bit7 transfer-hold, bit6 periodic enable, bit5 alarm enable, bit4 update-ended enable, bit3 unused, bit2 number format, bit1 hour mode, bit0 seasonal-time enable. A write stores every implemented bit, and bit3 always reads back 0.
- R3: Each control bit drives its own output, with 1 meaning enabled, binary (bit2), 24-hour (bit1) or seasonal adjustment on (bit0).
- R4: Any control write with bit7 = 1 leaves the update-ended enable at 0, whatever bit4 of the written value is.
- R5: A `sec_tick` sampled while no update is in flight sets `uip` at that edge. `upd_go` then pulses high for exactly one cycle, LEAD_CYC edges after the tick edge, while `uip` stays high.
- R6: `upd_done` sampled after the `upd_go` pulse ends the update, and `uip` is 0 from that edge. `upd_done` at any other time is ignored.
- R7: While transfer-hold is 1, `uip` reads 0 and `xfer_block` is 1. The update sequence itself continues: `upd_go` still comes LEAD_CYC edges after the tick, and clearing the hold bit mid-update brings `uip` back.
- R8: The status byte (host_sel=0) carries `uip` in bit7 and the interrupt request in bit6, with other bits 0. The request is set when an update ends while the update-ended enable is 1 and transfer-hold is 0.
- R9: A host read of the status byte (host_rd with host_sel=0) clears the request at the next edge. A request set in the same cycle as the read is kept.
- R10: A `sec_tick` arriving while an update is in flight is ignored: it neither restarts the lead count nor adds a second `upd_go` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 1 | Byte select: 0 status, 1 control |
| host_wr | input | 1 | Write strobe (control byte only) |
| host_rd | input | 1 | Read strobe; a status read clears the request |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data of the selected byte |
| sec_tick | input | 1 | One-second tick that opens an update |
| upd_done | input | 1 | Completion strobe from the timekeeping counters |
| upd_go | output | 1 | Start pulse to the timekeeping counters |
| uip | output | 1 | Update-in-progress flag |
| upd_irq | output | 1 | Update-ended interrupt request |
| xfer_block | output | 1 | Blocks transfer of new time to user-visible registers |
| en_periodic | output | 1 | Periodic interrupt enable |
| en_alarm | output | 1 | Alarm interrupt enable |
| en_update | output | 1 | Update-ended interrupt enable |
| fmt_binary | output | 1 | 1 binary, 0 BCD |
| fmt_24h | output | 1 | 1 24-hour, 0 12-hour |
| dst_en | output | 1 | Seasonal-time adjustment enable |

## Verification
The assertions assume that the counters return `upd_done` only after seeing `upd_go`, and that `sec_tick` and `upd_done` are single-cycle strobes sampled on the rising edge. The stimulus raises each strobe for exactly one cycle. It asserts `upd_done` only once `upd_go` has been seen, except in the one directed case where a stray completion must be ignored. Host writes and status reads are held for one cycle, and inputs change just after an edge.

// File: rtl/rtc_upd_pkg.sv
package rtc_upd_pkg;

    localparam int unsigned REG_W   = 8;
    localparam int unsigned B_HOLD  = 7;
    localparam int unsigned B_PER   = 6;
    localparam int unsigned B_ALM   = 5;
    localparam int unsigned B_UEN   = 4;
    localparam int unsigned B_NUM   = 2;
    localparam int unsigned B_HRS   = 1;
    localparam int unsigned B_SEAS  = 0;
    localparam int unsigned S_BUSY  = 7;
    localparam int unsigned S_REQ   = 6;

    typedef struct packed {
        logic hold;
        logic per_en;
        logic alm_en;
        logic upd_en;
        logic num_bin;
        logic hr24;
        logic seas_en;
    } ctl_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_LEAD = 2'd1,
        SQ_WAIT = 2'd2
    } seq_e;

    function automatic logic [REG_W-1:0] ctl_to_byte(input ctl_t c);
        logic [REG_W-1:0] b;
        b         = '0;
        b[B_HOLD] = c.hold;
        b[B_PER]  = c.per_en;
        b[B_ALM]  = c.alm_en;
        b[B_UEN]  = c.upd_en;
        b[B_NUM]  = c.num_bin;
        b[B_HRS]  = c.hr24;
        b[B_SEAS] = c.seas_en;
        return b;
    endfunction

endpackage

// File: rtl/rtc_ctl_reg.sv
module rtc_ctl_reg
    import rtc_upd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output ctl_t             ctl,
    output logic [REG_W-1:0] rdata
);

    typedef struct packed {
        ctl_t ctl;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctl.hold    = wdata[B_HOLD];
            st_d.ctl.per_en  = wdata[B_PER];
            st_d.ctl.alm_en  = wdata[B_ALM];
            // a set hold bit wins over the written update-ended enable
            st_d.ctl.upd_en  = wdata[B_UEN] & ~wdata[B_HOLD];
            st_d.ctl.num_bin = wdata[B_NUM];
            st_d.ctl.hr24    = wdata[B_HRS];
            st_d.ctl.seas_en = wdata[B_SEAS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl   = st_q.ctl;
    assign rdata = ctl_to_byte(st_q.ctl);

    a_r4_hold_clears_uen: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wdata[B_HOLD] |=> !ctl.upd_en);

    a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wdata[B_HOLD] |=> rdata == ($past(wdata) & 8'hF7));

endmodule

// File: rtl/rtc_upd_seq.sv
module rtc_upd_seq
    import rtc_upd_pkg::*;
#(
    parameter int unsigned LEAD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic done,
    output logic active,
    output logic go,
    output logic done_evt
);

    localparam int unsigned CNT_W = (LEAD_CYC > 1) ? $clog2(LEAD_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LEAD_CYC - 1);

    typedef struct packed {
        seq_e             ph;
        logic [CNT_W-1:0] cnt;
        logic             go;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.go = 1'b0;
        unique case (st_q.ph)
            SQ_IDLE: begin
                if (tick) begin
                    st_d.ph  = SQ_LEAD;
                    st_d.cnt = CNT_LOAD;
                end
            end
            SQ_LEAD: begin
                if (st_q.cnt == '0) begin
                    st_d.ph = SQ_WAIT;
                    st_d.go = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            SQ_WAIT: begin
                if (done) st_d.ph = SQ_IDLE;
            end
            default: st_d.ph = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: SQ_IDLE, cnt: '0, go: 1'b0};
        else        st_q <= st_d;
    end

    assign active   = (st_q.ph != SQ_IDLE);
    assign go       = st_q.go;
    assign done_evt = done && (st_q.ph == SQ_WAIT);

    a_r5_go_single: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> !go);

    a_r5_go_after_lead: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(go) |-> $past(st_q.ph == SQ_LEAD));

    a_r6_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> !active);

    a_r10_tick_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == SQ_WAIT) && tick && !done |=> (st_q.ph == SQ_WAIT) && !go);

endmodule

// File: rtl/rtc_irq_flag.sv
module rtc_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_rd,
    output logic req
);

    typedef struct packed {
        logic req;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_rd)  st_d.req = 1'b0;
        if (set_evt) st_d.req = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req = st_q.req;

    a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> req);

    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr_rd && !set_evt |=> !req);

endmodule

// File: rtl/rtc_upd_ctrl.sv
module rtc_upd_ctrl
    import rtc_upd_pkg::*;
#(
    parameter int unsigned LEAD_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_sel,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       sec_tick,
    input  logic       upd_done,
    output logic       upd_go,
    output logic       uip,
    output logic       upd_irq,
    output logic       xfer_block,
    output logic       en_periodic,
    output logic       en_alarm,
    output logic       en_update,
    output logic       fmt_binary,
    output logic       fmt_24h,
    output logic       dst_en
);

    ctl_t             ctl;
    logic [REG_W-1:0] ctl_byte;
    logic [REG_W-1:0] stat_byte;
    logic             seq_active;
    logic             seq_done;
    logic             req;

    rtc_ctl_reg u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (host_wr & host_sel),
        .wdata (host_wdata),
        .ctl   (ctl),
        .rdata (ctl_byte)
    );

    rtc_upd_seq #(.LEAD_CYC(LEAD_CYC)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sec_tick),
        .done     (upd_done),
        .active   (seq_active),
        .go       (upd_go),
        .done_evt (seq_done)
    );

    rtc_irq_flag u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (seq_done & ctl.upd_en & ~ctl.hold),
        .clr_rd  (host_rd & ~host_sel),
        .req     (req)
    );

    always_comb begin
        uip               = seq_active & ~ctl.hold;
        stat_byte         = '0;
        stat_byte[S_BUSY] = uip;
        stat_byte[S_REQ]  = req;
        host_rdata        = host_sel ? ctl_byte : stat_byte;
    end

    assign upd_irq     = req;
    assign xfer_block  = ctl.hold;
    assign en_periodic = ctl.per_en;
    assign en_alarm    = ctl.alm_en;
    assign en_update   = ctl.upd_en;
    assign fmt_binary  = ctl.num_bin;
    assign fmt_24h     = ctl.hr24;
    assign dst_en      = ctl.seas_en;

    a_r8_no_req_when_held: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done && ctl.hold && !req |=> !upd_irq);

endmodule

// File: tb/rtc_upd_ctrl_tb.sv
`timescale 1ns/1ps
module rtc_upd_ctrl_tb;

    localparam int LEAD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       sec_tick = 1'b0, upd_done = 1'b0;
    logic       upd_go, uip, upd_irq, xfer_block;
    logic       en_periodic, en_alarm, en_update, fmt_binary, fmt_24h, dst_en;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    rtc_upd_ctrl #(.LEAD_CYC(LEAD)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .sec_tick(sec_tick), .upd_done(upd_done), .upd_go(upd_go), .uip(uip),
        .upd_irq(upd_irq), .xfer_block(xfer_block), .en_periodic(en_periodic),
        .en_alarm(en_alarm), .en_update(en_update), .fmt_binary(fmt_binary),
        .fmt_24h(fmt_24h), .dst_en(dst_en)
    );

    // {written value, expected control readback}
    localparam logic [15:0] VEC [10] = '{
        {8'hFF, 8'hE7}, {8'h7F, 8'h77}, {8'h10, 8'h10}, {8'h90, 8'h80},
        {8'h04, 8'h04}, {8'h02, 8'h02}, {8'h01, 8'h01}, {8'h40, 8'h40},
        {8'h20, 8'h20}, {8'h08, 8'h00}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        host_sel = 1'b1; host_wr = 1'b1; host_wdata = v;
        step();
        host_wr = 1'b0;
    endtask

    task automatic rd_stat(output logic [7:0] v);
        host_sel = 1'b0; host_rd = 1'b1;
        #1 v = host_rdata;
        step();
        host_rd = 1'b0;
    endtask

    function automatic logic [7:0] outs();
        return {1'b0, xfer_block, en_periodic, en_alarm, en_update, fmt_binary, fmt_24h, dst_en};
    endfunction

    // pulses sec_tick and returns the number of edges until upd_go, counting the tick edge as 0
    task automatic run_lead(input string tag, input logic exp_uip, output int n);
        logic uip_ok;
        sec_tick = 1'b1;
        step();
        sec_tick = 1'b0;
        n = 0;
        uip_ok = (uip == exp_uip);
        while (!upd_go && n < 50) begin
            step();
            n++;
            uip_ok = uip_ok && (uip == exp_uip);
        end
        chk({tag, " uip during lead"}, {7'd0, uip_ok}, 8'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] s;
        int n;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        // R1 reset state
        host_sel = 1'b1; #1 chk("R1 control byte", host_rdata, 8'h00);
        host_sel = 1'b0; #1 chk("R1 status byte", host_rdata, 8'h00);
        chk("R1 outputs", {4'd0, uip, upd_irq, upd_go, |outs()}, 8'h00);

        // R2/R3 table walk
        for (int i = 0; i < 10; i++) begin
            wr_ctl(VEC[i][15:8]);
            host_sel = 1'b1;
            #1 chk("R2 readback", host_rdata, VEC[i][7:0]);
            chk("R3 outputs", outs(), {1'b0, VEC[i][7:4], VEC[i][2:0]});
        end

        // R4 hold write clears update-ended enable
        wr_ctl(8'h10);
        wr_ctl(8'h90);
        chk("R4 uen cleared", {7'd0, en_update}, 8'd0);

        // R5/R6/R8/R9/R10 normal update with interrupt
        wr_ctl(8'h10);
        run_lead("R5", 1'b1, n);
        chk("R5 lead length", 8'(n), 8'(LEAD));
        chk("R5 uip at go", {7'd0, uip}, 8'd1);
        step();
        chk("R5 go single cycle", {7'd0, upd_go}, 8'd0);
        sec_tick = 1'b1; step(); sec_tick = 1'b0;
        chk("R10 tick in flight", {6'd0, uip, upd_go}, 8'b10);
        step();
        chk("R10 no second go", {7'd0, upd_go}, 8'd0);
        upd_done = 1'b1; step(); upd_done = 1'b0;
        chk("R6 uip cleared", {7'd0, uip}, 8'd0);
        chk("R8 request set", {7'd0, upd_irq}, 8'd1);
        rd_stat(s);
        chk("R8 status byte", s, 8'h40);
        rd_stat(s);
        chk("R9 read cleared", s, 8'h00);
        repeat (LEAD + 2) step();
        chk("R10 no restart", {6'd0, uip, upd_go}, 8'd0);

        // R6 stray completion ignored
        upd_done = 1'b1; step(); upd_done = 1'b0;
        chk("R6 stray done", {6'd0, uip, upd_irq}, 8'd0);

        // R7 hold masks uip, sequence continues, no request
        wr_ctl(8'h80);
        chk("R7 xfer_block", {7'd0, xfer_block}, 8'd1);
        run_lead("R7", 1'b0, n);
        chk("R7 lead continues", 8'(n), 8'(LEAD));
        upd_done = 1'b1; step(); upd_done = 1'b0;
        chk("R8 no request under hold", {7'd0, upd_irq}, 8'd0);

        // R7 hold toggled mid-update
        wr_ctl(8'h10);
        sec_tick = 1'b1; step(); sec_tick = 1'b0;
        chk("R7 uip before hold", {7'd0, uip}, 8'd1);
        wr_ctl(8'h80);
        chk("R7 uip masked", {7'd0, uip}, 8'd0);
        wr_ctl(8'h10);
        chk("R7 uip restored", {7'd0, uip}, 8'd1);
        n = 0;
        while (!upd_go && n < 50) begin step(); n++; end
        step();
        upd_done = 1'b1; step(); upd_done = 1'b0;
        chk("R8 request after restore", {7'd0, upd_irq}, 8'd1);
        rd_stat(s);

        // R9 set wins over same-cycle clear
        run_lead("R9", 1'b1, n);
        step();
        upd_done = 1'b1; host_sel = 1'b0; host_rd = 1'b1;
        step();
        upd_done = 1'b0; host_rd = 1'b0;
        chk("R9 set wins", {7'd0, upd_irq}, 8'd1);
        rd_stat(s);
        chk("R9 clear after read", {7'd0, upd_irq}, 8'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule